// File: doc/BRIEF.md
# Dual-Rate Overlaid Serial Transmitter

This block drives one serial line that two receivers read at different rates. A receiver sampling at 9600 baud sees an ordinary 8N1 character stream. A receiver sampling at 115200 baud, twelve times faster, sees a train of complete 12-bit frames. Each slow bit period holds exactly one such fast frame. The fast frame is shaped so that most of its bits sit at the slow bit's level, and every fast frame that stands for a slow mark bit can carry one extra side bit.

Bytes for the slow stream arrive on a valid/ready port. Side bits arrive on a second valid/ready port and are taken one at a time, only when a slow mark bit begins. When no side bit is waiting, the mark frame goes out with all data ones and the slow stream does not wait. A counter divides the system clock down to the fast bit rate, and every change on the line lines up with that tick.

Top module: `dro_uart_tx`

## Requirements
- R1: While reset is held, and right after it, `tx_out` is 1, `byte_ready` is 1 and `aux_ready` is 0.
- R2: Each fast bit lasts exactly CLK_HZ/(12*SLOW_BAUD) clock cycles. `tx_out` changes only on the clock edge that ends a fast bit period.
- R3: A byte is taken on an edge where `byte_valid` and `byte_ready` are both 1. `byte_ready` then stays 0 until the last of ten slow bits has started: a space start bit, the eight data bits LSB first, and a mark stop bit. `byte_valid` has no effect while `byte_ready` is 0.
- R4: Each slow bit is sent as twelve fast bits in this order: one mark, one space, eight data bits LSB first, then two marks.
- R5: For a slow space bit, all eight fast data bits are 0.
- R6: For a slow mark bit with a side bit waiting, the fast data byte is 0xFF when the side bit is 1 and 0xFE when it is 0. The side bit is therefore the third fast bit of that slow bit period.
- R7: `aux_ready` is 1 for one clock cycle at the start of each slow mark bit and at no other time. Side bits are used in arrival order, and slow space bits use none.
- R8: A slow mark bit with no side bit waiting is sent with fast data 0xFF, and the slow stream continues without delay.
- R9: When no byte is being sent, `tx_out` holds 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_data | input | 8 | Byte for the slow stream |
| byte_valid | input | 1 | `byte_data` is offered |
| byte_ready | output | 1 | Transmitter is idle and will take a byte |
| aux_bit | input | 1 | Side bit for the fast stream |
| aux_valid | input | 1 | `aux_bit` is offered |
| aux_ready | output | 1 | Side bit is taken on this edge |
| tx_out | output | 1 | Serial line |

## Verification
The hardest case to reach is a mix within one byte: some slow mark bits carry a side bit and later ones fall back to 0xFF because the side-bit supply has run out. Getting there needs close control of how many side bits are waiting when each mark bit starts. The stimulus loads a counted number of side bits only while the line is idle. It then sends bytes whose mark count is larger than, equal to, or smaller than that number, including an all-space byte whose only mark is the stop bit. After each byte, the number of side bits left over is compared with the count the bench expects.

// File: rtl/dro_pkg.sv
package dro_pkg;
  localparam int FAST_LEN = 12;
  localparam int SLOW_LEN = 10;
  localparam int DATA_W   = 8;
  localparam int FIDX_W   = $clog2(FAST_LEN);
  localparam int SIDX_W   = $clog2(SLOW_LEN);

  typedef logic [FAST_LEN-1:0] fast_frame_t;
  typedef logic [SLOW_LEN-1:0] slow_frame_t;
endpackage

// File: rtl/dro_tick.sv
module dro_tick #(
  parameter int DIV = 1085
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  generate
    if (DIV > 1) begin : g_gap
      // R2: ticks are never on back-to-back cycles
      a_r2_tick_gap: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/dro_fast_frame.sv
module dro_fast_frame
  import dro_pkg::*;
(
  input  logic        level,
  input  logic        aux,
  output fast_frame_t frame
);
  logic [DATA_W-1:0] data;

  always_comb begin
    if (level) data = {{(DATA_W-1){1'b1}}, aux};
    else       data = '0;
    // index 0 leaves the line first: mark, space, data LSB first, two marks
    frame = {2'b11, data, 1'b0, 1'b1};
  end
endmodule

// File: rtl/dro_slow_seq.sv
module dro_slow_seq
  import dro_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic              aux_bit,
  input  logic              aux_valid,
  output logic              aux_ready,
  output logic              tx_out
);
  localparam logic [FIDX_W-1:0] FLAST = FIDX_W'(FAST_LEN - 1);
  localparam logic [SIDX_W-1:0] SLAST = SIDX_W'(SLOW_LEN - 1);

  logic              busy;
  slow_frame_t       slow_sr;
  logic [SIDX_W-1:0] slow_cnt;
  logic [FIDX_W-1:0] fast_idx;
  fast_frame_t       fast_sr;
  fast_frame_t       frame;
  logic              bit_start;

  dro_fast_frame u_frame (
    .level (slow_sr[0]),
    .aux   (aux_valid ? aux_bit : 1'b1),
    .frame (frame)
  );

  assign byte_ready = !busy;
  assign bit_start  = busy && tick && (fast_idx == '0);
  assign aux_ready  = bit_start && slow_sr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      slow_sr  <= '1;
      slow_cnt <= '0;
      fast_idx <= '0;
      fast_sr  <= '1;
      tx_out   <= 1'b1;
    end else if (!busy && byte_valid) begin
      busy     <= 1'b1;
      slow_sr  <= {1'b1, byte_data, 1'b0};
      slow_cnt <= '0;
      fast_idx <= '0;
    end else if (busy && tick) begin
      if (fast_idx == '0) begin
        tx_out  <= frame[0];
        fast_sr <= frame >> 1;
      end else begin
        tx_out  <= fast_sr[0];
        fast_sr <= fast_sr >> 1;
      end
      if (fast_idx == FLAST) begin
        fast_idx <= '0;
        slow_sr  <= {1'b1, slow_sr[SLOW_LEN-1:1]};
        if (slow_cnt == SLAST) busy <= 1'b0;
        else                   slow_cnt <= slow_cnt + 1'b1;
      end else begin
        fast_idx <= fast_idx + 1'b1;
      end
    end
  end

  // R9: line rests at mark whenever nothing is in flight
  a_r9_idle_mark: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx_out);
  // R4: every fast frame opens with a mark then a space
  a_r4_lead_mark: assert property (@(posedge clk) disable iff (rst)
    bit_start |=> tx_out);
  a_r4_start_space: assert property (@(posedge clk) disable iff (rst)
    (busy && tick && fast_idx == FIDX_W'(1)) |=> !tx_out);
  // R5: data bits of a space frame are all space
  a_r5_space_data: assert property (@(posedge clk) disable iff (rst)
    (busy && tick && !slow_sr[0] && fast_idx >= FIDX_W'(2) && fast_idx <= FIDX_W'(9))
      |=> !tx_out);
  // R3: an accepted byte closes the input at once
  a_r3_ready_drop: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && byte_ready) |=> !byte_ready);
endmodule

// File: rtl/dro_uart_tx.sv
module dro_uart_tx
  import dro_pkg::*;
#(
  parameter int CLK_HZ    = 125_000_000,
  parameter int SLOW_BAUD = 9600
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic              aux_bit,
  input  logic              aux_valid,
  output logic              aux_ready,
  output logic              tx_out
);
  localparam int FAST_BAUD = SLOW_BAUD * FAST_LEN;
  localparam int DIV_RAW   = CLK_HZ / FAST_BAUD;
  localparam int DIV       = (DIV_RAW < 1) ? 1 : DIV_RAW;

  logic tick;

  dro_tick #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  dro_slow_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .byte_data  (byte_data),
    .byte_valid (byte_valid),
    .byte_ready (byte_ready),
    .aux_bit    (aux_bit),
    .aux_valid  (aux_valid),
    .aux_ready  (aux_ready),
    .tx_out     (tx_out)
  );

  // R2: the line only moves on a baud tick
  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(tx_out));
  // R7: side bits are only taken on a tick
  a_r7_aux_on_tick: assert property (@(posedge clk) disable iff (rst)
    aux_ready |-> tick);
endmodule

// File: tb/sim_dro_uart_tx.sv
module sim_dro_uart_tx;
  localparam int DIV = 4;
  localparam int SLOW_BAUD = 9600;
  localparam int CLK_HZ = SLOW_BAUD * 12 * DIV;

  typedef struct {
    bit    v;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] byte_data = 8'h00;
  logic       byte_valid = 1'b0;
  logic       byte_ready;
  logic       aux_bit = 1'b0;
  logic       aux_valid = 1'b0;
  logic       aux_ready;
  logic       tx_out;

  int   errors = 0;
  int   checks = 0;
  int   ecnt = 0;
  bit   last_mid = 1'b1;
  bit   aux_pend = 1'b0;
  exp_t exp_q[$];
  bit   aux_src[$];
  bit   aux_model[$];

  always #4 clk = ~clk;

  dro_uart_tx #(.CLK_HZ(CLK_HZ), .SLOW_BAUD(SLOW_BAUD)) u0 (
    .clk(clk), .rst(rst), .byte_data(byte_data), .byte_valid(byte_valid),
    .byte_ready(byte_ready), .aux_bit(aux_bit), .aux_valid(aux_valid),
    .aux_ready(aux_ready), .tx_out(tx_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (edge %0d)", req, act, exp, ecnt);
    end
  endtask

  always @(posedge clk) if (!rst) ecnt <= ecnt + 1;

  // side-bit source: a handshake seen at a negedge completes at the next posedge
  always @(negedge clk) begin
    if (aux_pend) void'(aux_src.pop_front());
    aux_pend  = aux_valid && aux_ready;
    aux_valid = (aux_src.size() > 0);
    aux_bit   = (aux_src.size() > 0) ? aux_src[0] : 1'b0;
  end

  // monitor: mid-bit sample against the scoreboard, late sample for hold time
  always @(negedge clk) begin
    if (!rst && ecnt > 0 && (ecnt % DIV) == DIV / 2) begin
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(tx_out == e.v, e.req, int'(tx_out), int'(e.v));
      end else begin
        chk(tx_out == 1'b1, "R9", int'(tx_out), 1);
      end
      last_mid = tx_out;
    end
    if (!rst && ecnt > DIV && (ecnt % DIV) == DIV - 1)
      chk(tx_out == last_mid, "R2", int'(tx_out), int'(last_mid));
  end

  task automatic add_aux(input bit b);
    aux_src.push_back(b);
    aux_model.push_back(b);
  endtask

  task automatic push_expected(input logic [7:0] d);
    bit [9:0] slow;
    slow = {1'b1, d, 1'b0};
    for (int s = 0; s < 10; s++) begin
      bit lvl, a, used;
      lvl = slow[s];
      used = 1'b0;
      a = 1'b1;
      if (lvl && aux_model.size() > 0) begin
        a = aux_model.pop_front();
        used = 1'b1;
      end
      for (int f = 0; f < 12; f++) begin
        exp_t e;
        case (f)
          0:       begin e.v = 1'b1; e.req = "R4"; end
          1:       begin e.v = 1'b0; e.req = "R4"; end
          2:       begin e.v = lvl ? a : 1'b0; e.req = lvl ? (used ? "R6" : "R8") : "R5"; end
          10, 11:  begin e.v = 1'b1; e.req = "R4"; end
          default: begin e.v = lvl; e.req = lvl ? "R6" : "R5"; end
        endcase
        exp_q.push_back(e);
      end
    end
  endtask

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk);
    while (!(byte_ready && (ecnt % DIV) == DIV / 2)) @(negedge clk);
    byte_data  = d;
    byte_valid = 1'b1;
    @(negedge clk);
    chk(byte_ready == 1'b0, "R3", int'(byte_ready), 0);
    byte_valid = 1'b0;
    push_expected(d);
  endtask

  task automatic wait_done();
    while (exp_q.size() > 0 || !byte_ready) @(negedge clk);
    repeat (3 * DIV) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R3: watchdog expired got 0 expected 1");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state under reset
    chk(tx_out == 1'b1, "R1", int'(tx_out), 1);
    chk(byte_ready == 1'b1, "R1", int'(byte_ready), 1);
    chk(aux_ready == 1'b0, "R1", int'(aux_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_out == 1'b1, "R1", int'(tx_out), 1);
    chk(aux_ready == 1'b0, "R1", int'(aux_ready), 0);
    repeat (5 * DIV) @(negedge clk);

    // R8: no side bits at all
    send_byte(8'h55);
    wait_done();

    // R6/R7: exactly as many side bits as mark bits in 0xA3 (five)
    add_aux(1'b0); add_aux(1'b1); add_aux(1'b0); add_aux(1'b0); add_aux(1'b0);
    repeat (2) @(negedge clk);
    send_byte(8'hA3);
    wait_done();
    chk(aux_src.size() == aux_model.size(), "R7", aux_src.size(), aux_model.size());

    // R8: supply runs out partway through a byte
    add_aux(1'b0); add_aux(1'b0);
    repeat (2) @(negedge clk);
    send_byte(8'hFF);
    wait_done();
    chk(aux_src.size() == 0, "R8", aux_src.size(), 0);

    // R7: space bits must leave side bits untouched; only the stop mark takes one
    add_aux(1'b0); add_aux(1'b1); add_aux(1'b0);
    repeat (2) @(negedge clk);
    send_byte(8'h00);
    // R3: an offer while busy is ignored
    byte_data  = 8'h81;
    byte_valid = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(byte_ready == 1'b0, "R3", int'(byte_ready), 0);
    end
    byte_valid = 1'b0;
    wait_done();
    chk(aux_src.size() == 2, "R7", aux_src.size(), 2);
    chk(aux_src.size() == aux_model.size(), "R7", aux_src.size(), aux_model.size());

    // R3: back-to-back bytes, the remaining side bits go to the first marks
    send_byte(8'h3C);
    send_byte(8'hC3);
    wait_done();
    chk(aux_src.size() == 0, "R7", aux_src.size(), 0);
    chk(tx_out == 1'b1, "R9", int'(tx_out), 1);
    chk(aux_ready == 1'b0, "R7", int'(aux_ready), 0);

    finish_run();
  end
endmodule